// File: doc/BRIEF.md
# Chunked Mailbox Staging Sequencer

This block is a bus master that copies an image held in a word-addressed source memory into a device mailbox. The mailbox is four 32-bit registers on a simple register bus. After a start pulse the sequencer checks that the image length is a whole number of 32-bit words. It then resets the mailbox with an abort command and repeats a transaction loop. Each pass writes a request object, starts the device, polls its status at a fixed pace with a poll limit, and reads a four-word response. The response names the byte offset the device wants next.

The device chooses the next offset. It may ask for a chunk it has already received. The loop ends in one of three ways: the device returns the all-ones end offset, the bytes already sent plus the next chunk would exceed twice the image length, or an error is detected. The result is a 3-bit code and a count of bytes sent. Both hold, together with a done flag, until the next start.

Register bus timing: a write takes one cycle with `mb_wr` high. For a read, `mb_rd` is high for one cycle and the device returns `mb_rdata` in the following cycle, holding it until its next read. The source memory behaves the same way: data arrives on `src_data` in the cycle after `src_rd`. Mailbox byte offsets are: control 0x0, status 0x4, write-data 0x8, read-data 0xC.

Top module: `mbox_stager`

## Requirements
- R1: A start with an image length whose two low bits are not zero ends at once with error code 1 and done set, and makes no mailbox access.
- R2: The first mailbox access after an accepted start is a write of 0x1 (abort) to control. No status read happens before the first request is started.
- R3: Each request is written to write-data in this order: header low word {8'h00, 8'h0B, 16'h8086}, header high word equal to (16 + chunk bytes)/4, command low word 0x3, command high word 0x0, then the chunk as words read from source word address offset/4 upward.
- R4: The chunk length is the smaller of PAGE_BYTES and (image length − current offset).
- R5: After the data, the sequencer writes 0x8000_0000 (go) to control. It reads status first POLL_DIV+1 cycles after the go write, and then once every POLL_DIV+2 cycles. It moves on to the response when status bit 31 (ready) is set.
- R6: If status bit 2 is set when polling stops, the run ends with error code 2.
- R7: If ready is still clear after MAX_POLLS status reads and bit 2 is clear, the run ends with error code 3.
- R8: The response is four reads of read-data: header low, header high, next offset, response status. Each read is followed by a write of 0 to read-data.
- R9: A response header other than low 0x000B_8086, high 0x0000_0004 ends the run with error code 4.
- R10: A next offset that is not 0xFFFF_FFFF and is larger than the image length ends the run with error code 5.
- R11: Response status bit 2 set ends the run with error code 6.
- R12: A next offset of 0xFFFF_FFFF ends the run with code 0. Any other accepted offset, including one already sent, is the start of the next chunk. `bytes_sent` is the sum of the chunk lengths requested.
- R13: If bytes sent plus the next chunk would exceed twice the image length, the run ends with code 7 and no further request is written.
- R14: `done`, `err_code` and `bytes_sent` hold until the next accepted start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| img_len | input | 32 | Image length in bytes, sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; holds until next start |
| err_code | output | 3 | Result code (0 success, 1..7 as in requirements) |
| bytes_sent | output | 32 | Total chunk bytes requested in this run |
| src_rd | output | 1 | Source memory read strobe |
| src_addr | output | SRC_AW | Source word address |
| src_data | input | 32 | Source read data, valid the cycle after src_rd |
| mb_wr | output | 1 | Mailbox register write strobe |
| mb_rd | output | 1 | Mailbox register read strobe |
| mb_addr | output | 4 | Mailbox register byte offset |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after mb_rd |

## Verification
The mailbox model and the bench checks observe the bus at the falling edge. Each write or read is therefore seen in the same cycle the sequencer drives it, and read data is returned so that it is stable on the next rising edge, one cycle after the strobe. Poll pacing is checked by cycle count. The first status read must come exactly POLL_DIV+1 cycles after the go write. The request contents are checked word by word at the go write, against an offset the bench tracks from its own response script. Results are sampled only once `done` is seen at a falling edge, which is the cycle after the final decision. Hold behaviour is checked again some cycles later.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_ALIGN   = 3'd1,
    E_IO      = 3'd2,
    E_TIMEOUT = 3'd3,
    E_HDR     = 3'd4,
    E_OFFSET  = 3'd5,
    E_PROTO   = 3'd6,
    E_SIZE    = 3'd7
  } mbs_err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ABORT,
    S_PLAN,
    S_HDR_LO,
    S_HDR_HI,
    S_CMD_LO,
    S_CMD_HI,
    S_FETCH,
    S_PUSH,
    S_GO,
    S_WAIT,
    S_POLL,
    S_JUDGE,
    S_RSP_RD,
    S_RSP_ACK,
    S_EVAL
  } mbs_state_e;

  localparam logic [3:0]  REG_CTRL  = 4'h0;
  localparam logic [3:0]  REG_STAT  = 4'h4;
  localparam logic [3:0]  REG_WDATA = 4'h8;
  localparam logic [3:0]  REG_RDATA = 4'hC;

  localparam logic [31:0] CTRL_ABORT = 32'h0000_0001;
  localparam logic [31:0] CTRL_GO    = 32'h8000_0000;
  localparam int          STAT_READY = 31;
  localparam int          STAT_FAULT = 2;
  localparam int          RSP_FAULT  = 2;

  localparam logic [15:0] VENDOR_CODE = 16'h8086;
  localparam logic [7:0]  OBJ_KIND    = 8'h0B;
  localparam logic [31:0] CMD_LOAD    = 32'h0000_0003;
  localparam logic [31:0] OFF_END     = 32'hFFFF_FFFF;
  localparam int          HDR_BYTES   = 16;

  function automatic logic [63:0] mbox_hdr(input logic [31:0] dwords);
    return {dwords, 8'h00, OBJ_KIND, VENDOR_CODE};
  endfunction

endpackage

// File: rtl/mbs_pacer.sv
module mbs_pacer #(
  parameter int POLL_DIV  = 200000,
  parameter int MAX_POLLS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic wait_en,
  input  logic polled,
  output logic tick,
  output logic last_poll
);

  localparam int DW = $clog2(POLL_DIV + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [DW-1:0] div_q, div_d;
  logic [PW-1:0] poll_q, poll_d;

  assign tick      = wait_en && (div_q == DW'(POLL_DIV - 1));
  assign last_poll = (poll_q == PW'(MAX_POLLS - 1));

  always_comb begin
    div_d  = div_q;
    poll_d = poll_q;
    if (arm) begin
      div_d  = '0;
      poll_d = '0;
    end else begin
      if (wait_en) begin
        if (tick) div_d = '0;
        else      div_d = div_q + DW'(1);
      end
      if (polled) poll_d = poll_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      poll_q <= '0;
    end else begin
      div_q  <= div_d;
      poll_q <= poll_d;
    end
  end

  AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    polled |-> (poll_q < PW'(MAX_POLLS))); // R7

endmodule

// File: rtl/mbs_chunk.sv
module mbs_chunk #(
  parameter int PAGE_BYTES = 4096
) (
  input  logic [31:0] img_len,
  input  logic [31:0] offset,
  input  logic [31:0] sent,
  output logic [31:0] chunk_bytes,
  output logic [31:0] obj_dwords,
  output logic        over_budget
);
  import mbs_pkg::*;

  logic [31:0] remain;
  logic [33:0] next_total;
  logic [33:0] budget;

  always_comb begin
    remain      = img_len - offset;
    chunk_bytes = (remain < 32'(PAGE_BYTES)) ? remain : 32'(PAGE_BYTES);
    obj_dwords  = (chunk_bytes + 32'(HDR_BYTES)) >> 2;
    next_total  = {2'b00, sent} + {2'b00, chunk_bytes};
    budget      = {1'b0, img_len, 1'b0};
    over_budget = next_total > budget;
  end

endmodule

// File: rtl/mbox_stager.sv
module mbox_stager #(
  parameter int PAGE_BYTES = 4096,
  parameter int POLL_DIV   = 200000,
  parameter int MAX_POLLS  = 10000,
  parameter int SRC_AW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       img_len,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic [31:0]       bytes_sent,
  output logic              src_rd,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [31:0]       src_data,
  output logic              mb_wr,
  output logic              mb_rd,
  output logic [3:0]        mb_addr,
  output logic [31:0]       mb_wdata,
  input  logic [31:0]       mb_rdata
);
  import mbs_pkg::*;

  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int WIW        = $clog2(PAGE_WORDS + 1);

  mbs_state_e        st_q, st_d;
  logic [31:0]       len_q, len_d;
  logic [31:0]       off_q, off_d;
  logic [31:0]       sent_q, sent_d;
  logic [31:0]       chunk_q, chunk_d;
  logic [31:0]       obj_q, obj_d;
  logic [WIW-1:0]    widx_q, widx_d;
  logic [1:0]        ridx_q, ridx_d;
  logic [3:0][31:0]  rsp_q, rsp_d;
  mbs_err_e          err_q, err_d;
  logic              done_q, done_d;

  logic [31:0]       chunk_c, obj_c;
  logic              over_c;
  logic              tick, last_poll;
  logic [63:0]       req_hdr;
  logic [WIW-1:0]    chunk_words;
  logic              rsp_hdr_ok;
  logic [31:0]       rsp_off;

  mbs_chunk #(.PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .img_len     (len_q),
    .offset      (off_q),
    .sent        (sent_q),
    .chunk_bytes (chunk_c),
    .obj_dwords  (obj_c),
    .over_budget (over_c)
  );

  mbs_pacer #(.POLL_DIV(POLL_DIV), .MAX_POLLS(MAX_POLLS)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (st_q == S_GO),
    .wait_en   (st_q == S_WAIT),
    .polled    (st_q == S_JUDGE),
    .tick      (tick),
    .last_poll (last_poll)
  );

  assign req_hdr     = mbox_hdr(obj_q);
  assign chunk_words = WIW'(chunk_q >> 2);
  assign rsp_hdr_ok  = ({rsp_q[1], rsp_q[0]} == mbox_hdr(32'd4));
  assign rsp_off     = rsp_q[2];

  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign err_code   = err_q;
  assign bytes_sent = sent_q;

  always_comb begin
    st_d    = st_q;
    len_d   = len_q;
    off_d   = off_q;
    sent_d  = sent_q;
    chunk_d = chunk_q;
    obj_d   = obj_q;
    widx_d  = widx_q;
    ridx_d  = ridx_q;
    rsp_d   = rsp_q;
    err_d   = err_q;
    done_d  = done_q;
    mb_wr    = 1'b0;
    mb_rd    = 1'b0;
    mb_addr  = REG_CTRL;
    mb_wdata = '0;
    src_rd   = 1'b0;
    src_addr = off_q[SRC_AW+1:2] + SRC_AW'(widx_q);

    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          len_d  = img_len;
          off_d  = '0;
          sent_d = '0;
          err_d  = E_NONE;
          done_d = 1'b0;
          if (img_len[1:0] != 2'b00) begin
            err_d  = E_ALIGN;
            done_d = 1'b1;
          end else begin
            st_d = S_ABORT;
          end
        end
      end
      S_ABORT: begin
        mb_wr    = 1'b1;
        mb_addr  = REG_CTRL;
        mb_wdata = CTRL_ABORT;
        st_d     = S_PLAN;
      end
      S_PLAN: begin
        if (off_q == OFF_END) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (over_c) begin
          err_d  = E_SIZE;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          chunk_d = chunk_c;
          obj_d   = obj_c;
          sent_d  = sent_q + chunk_c;
          widx_d  = '0;
          st_d    = S_HDR_LO;
        end
      end
      S_HDR_LO: begin
        mb_wr    = 1'b1;
        mb_addr  = REG_WDATA;
        mb_wdata = req_hdr[31:0];
        st_d     = S_HDR_HI;
      end
      S_HDR_HI: begin
        mb_wr    = 1'b1;
        mb_addr  = REG_WDATA;
        mb_wdata = req_hdr[63:32];
        st_d     = S_CMD_LO;
      end
      S_CMD_LO: begin
        mb_wr    = 1'b1;
        mb_addr  = REG_WDATA;
        mb_wdata = CMD_LOAD;
        st_d     = S_CMD_HI;
      end
      S_CMD_HI: begin
        mb_wr    = 1'b1;
        mb_addr  = REG_WDATA;
        mb_wdata = '0;
        st_d     = (chunk_words == '0) ? S_GO : S_FETCH;
      end
      S_FETCH: begin
        src_rd = 1'b1;
        st_d   = S_PUSH;
      end
      S_PUSH: begin
        mb_wr    = 1'b1;
        mb_addr  = REG_WDATA;
        mb_wdata = src_data;
        widx_d   = widx_q + WIW'(1);
        st_d     = (widx_q == chunk_words - WIW'(1)) ? S_GO : S_FETCH;
      end
      S_GO: begin
        mb_wr    = 1'b1;
        mb_addr  = REG_CTRL;
        mb_wdata = CTRL_GO;
        st_d     = S_WAIT;
      end
      S_WAIT: begin
        if (tick) st_d = S_POLL;
      end
      S_POLL: begin
        mb_rd   = 1'b1;
        mb_addr = REG_STAT;
        st_d    = S_JUDGE;
      end
      S_JUDGE: begin
        if (mb_rdata[STAT_READY] || last_poll) begin
          if (mb_rdata[STAT_FAULT]) begin
            err_d  = E_IO;
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else if (!mb_rdata[STAT_READY]) begin
            err_d  = E_TIMEOUT;
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            ridx_d = '0;
            st_d   = S_RSP_RD;
          end
        end else begin
          st_d = S_WAIT;
        end
      end
      S_RSP_RD: begin
        mb_rd   = 1'b1;
        mb_addr = REG_RDATA;
        st_d    = S_RSP_ACK;
      end
      S_RSP_ACK: begin
        rsp_d[ridx_q] = mb_rdata;
        mb_wr    = 1'b1;
        mb_addr  = REG_RDATA;
        mb_wdata = '0;
        ridx_d   = ridx_q + 2'd1;
        st_d     = (ridx_q == 2'd3) ? S_EVAL : S_RSP_RD;
      end
      S_EVAL: begin
        st_d = S_PLAN;
        if (!rsp_hdr_ok) begin
          err_d  = E_HDR;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if ((rsp_off != OFF_END) && (rsp_off > len_q)) begin
          err_d  = E_OFFSET;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (rsp_q[3][RSP_FAULT]) begin
          err_d  = E_PROTO;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          off_d = rsp_off;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      len_q   <= '0;
      off_q   <= '0;
      sent_q  <= '0;
      chunk_q <= '0;
      obj_q   <= '0;
      widx_q  <= '0;
      ridx_q  <= '0;
      rsp_q   <= '0;
      err_q   <= E_NONE;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      len_q   <= len_d;
      off_q   <= off_d;
      sent_q  <= sent_d;
      chunk_q <= chunk_d;
      obj_q   <= obj_d;
      widx_q  <= widx_d;
      ridx_q  <= ridx_d;
      rsp_q   <= rsp_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  AST_ABORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mb_wr && mb_addr == REG_CTRL && mb_wdata == CTRL_ABORT)); // R2

  AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HDR_LO) |-> (chunk_q <= 32'(PAGE_BYTES) &&
      ({1'b0, off_q} + {1'b0, chunk_q}) <= {1'b0, len_q})); // R4

  AST_GO_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_addr == REG_CTRL && mb_wdata == CTRL_GO) |=> (!mb_rd && !mb_wr)); // R5

  AST_ACK_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_addr == REG_RDATA) |-> $past(mb_rd && mb_addr == REG_RDATA)); // R8

  AST_BUDGET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({2'b00, sent_q} <= {1'b0, len_q, 1'b0})); // R13

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(err_code) && $stable(bytes_sent))); // R14

endmodule

// File: tb/mbox_stager_tb_top.sv
`timescale 1ns/1ps
module mbox_stager_tb_top;

  localparam int PDIV  = 3;
  localparam int MPOLL = 5;
  localparam int PAGE  = 4096;
  localparam logic [31:0] ENDOFF = 32'hFFFF_FFFF;

  logic        clk, rst_n, start;
  logic [31:0] img_len;
  logic        busy, done;
  logic [2:0]  err_code;
  logic [31:0] bytes_sent;
  logic        src_rd;
  logic [15:0] src_addr;
  logic [31:0] src_data;
  logic        mb_wr, mb_rd;
  logic [3:0]  mb_addr;
  logic [31:0] mb_wdata, mb_rdata;

  mbox_stager #(.PAGE_BYTES(PAGE), .POLL_DIV(PDIV), .MAX_POLLS(MPOLL), .SRC_AW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .busy(busy), .done(done), .err_code(err_code), .bytes_sent(bytes_sent),
    .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
    .mb_wr(mb_wr), .mb_rd(mb_rd), .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk, n_bad;
  bit finished;

  // mailbox model state and script
  int          cyc, go_cyc, first_gap, wcnt, txn, aborts, stat_reads, early_stat;
  int          acks, ridx, poll_in_txn, bus_acc, req_bad, exp_off, cur_len;
  int          ready_after;
  bit          stat_err;
  logic [31:0] hdr_lo_rsp, rsp_stat;
  logic [31:0] off_script [0:7];
  logic [31:0] req [0:1100];

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic clear_model();
    go_cyc = 0; first_gap = -1; wcnt = 0; txn = 0; aborts = 0; stat_reads = 0;
    early_stat = 0; acks = 0; ridx = 0; poll_in_txn = 0; bus_acc = 0; req_bad = 0;
    exp_off = 0; ready_after = 2; stat_err = 0;
    hdr_lo_rsp = 32'h000B_8086; rsp_stat = 32'h1;
    for (int i = 0; i < 8; i++) off_script[i] = ENDOFF;
  endtask

  task automatic check_request();
    int chunk, rem;
    bit ok;
    rem   = cur_len - exp_off;
    chunk = (rem < PAGE) ? rem : PAGE;
    ok = (wcnt == 4 + chunk / 4);
    if (req[0] !== 32'h000B_8086) ok = 0;
    if (req[1] !== 32'((16 + chunk) / 4)) ok = 0;
    if (req[2] !== 32'h3) ok = 0;
    if (req[3] !== 32'h0) ok = 0;
    for (int i = 0; i < chunk / 4 && i < 1000; i++)
      if (req[4 + i] !== memf(16'(exp_off / 4 + i))) ok = 0;
    if (!ok) req_bad++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (src_rd) src_data <= memf(src_addr);
    if (mb_wr) begin
      bus_acc++;
      case (mb_addr)
        4'h0: begin
          if (mb_wdata == 32'h1) begin
            aborts++; wcnt = 0; ridx = 0;
          end else if (mb_wdata == 32'h8000_0000) begin
            check_request();
            if (off_script[txn] != ENDOFF && off_script[txn] <= 32'(cur_len))
              exp_off = off_script[txn];
            txn++; poll_in_txn = 0; wcnt = 0; ridx = 0; go_cyc = cyc;
          end
        end
        4'h8: begin
          if (wcnt < 1100) req[wcnt] = mb_wdata;
          wcnt++;
        end
        4'hC: begin
          if (mb_wdata == 32'h0) acks++;
          ridx++;
        end
        default: ;
      endcase
    end
    if (mb_rd) begin
      bus_acc++;
      if (mb_addr == 4'h4) begin
        stat_reads++;
        if (txn == 0) early_stat++;
        if (poll_in_txn == 0 && first_gap < 0) first_gap = cyc - go_cyc;
        poll_in_txn++;
        mb_rdata <= {(poll_in_txn > ready_after), 28'h0, stat_err, 2'b00};
      end else if (mb_addr == 4'hC) begin
        case (ridx)
          0: mb_rdata <= hdr_lo_rsp;
          1: mb_rdata <= 32'h4;
          2: mb_rdata <= off_script[(txn > 0) ? txn - 1 : 0];
          default: mb_rdata <= rsp_stat;
        endcase
      end
    end
  end

  task automatic launch(input int len);
    cur_len = len;
    @(negedge clk); start = 1'b1; img_len = 32'(len);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk("R14 reset done", {31'b0, done}, 32'h0);
    chk("R14 reset busy", {31'b0, busy}, 32'h0);
    chk("R14 reset err", {29'b0, err_code}, 32'h0);
    chk("R14 reset bus", 32'(bus_acc), 32'h0);
  endtask

  task automatic t_misaligned();
    clear_model();
    launch(10);
    wait_done();
    chk("R1 error code", {29'b0, err_code}, 32'd1);
    chk("R1 done", {31'b0, done}, 32'h1);
    chk("R1 no bus access", 32'(bus_acc), 32'h0);
  endtask

  task automatic t_normal();
    clear_model();
    off_script[0] = 32'd4096;
    launch(6000);
    repeat (50) @(negedge clk);
    start = 1'b1; img_len = 32'd4;    // R14 start while busy
    @(negedge clk); start = 1'b0;
    wait_done();
    chk("R12 code", {29'b0, err_code}, 32'd0);
    chk("R12 bytes sent", bytes_sent, 32'd6000);
    chk("R14 busy start ignored txn", 32'(txn), 32'd2);
    chk("R3 R4 request content", 32'(req_bad), 32'd0);
    chk("R2 single abort", 32'(aborts), 32'd1);
    chk("R2 no early status", 32'(early_stat), 32'd0);
    chk("R5 status reads", 32'(stat_reads), 32'd6);
    chk("R5 first poll gap", 32'(first_gap), 32'(PDIV + 1));
    chk("R8 acks", 32'(acks), 32'd8);
    repeat (10) @(negedge clk);
    chk("R14 done hold", {31'b0, done}, 32'h1);
    chk("R14 bytes hold", bytes_sent, 32'd6000);
  endtask

  task automatic t_repeat();
    clear_model();
    off_script[0] = 32'd4;
    launch(12);
    wait_done();
    chk("R12 repeat code", {29'b0, err_code}, 32'd0);
    chk("R12 repeat bytes", bytes_sent, 32'd20);
    chk("R4 R3 repeat request", 32'(req_bad), 32'd0);
  endtask

  task automatic t_budget();
    clear_model();
    off_script[0] = 32'd0; off_script[1] = 32'd0; off_script[2] = 32'd0;
    launch(8);
    wait_done();
    chk("R13 code", {29'b0, err_code}, 32'd7);
    chk("R13 bytes", bytes_sent, 32'd16);
    chk("R13 txn", 32'(txn), 32'd2);
  endtask

  task automatic t_status_err();
    clear_model();
    ready_after = 0; stat_err = 1;
    launch(16);
    wait_done();
    chk("R6 code", {29'b0, err_code}, 32'd2);
    chk("R6 reads", 32'(stat_reads), 32'd1);
  endtask

  task automatic t_timeout();
    clear_model();
    ready_after = 100;
    launch(16);
    wait_done();
    chk("R7 code", {29'b0, err_code}, 32'd3);
    chk("R7 reads", 32'(stat_reads), 32'(MPOLL));
  endtask

  task automatic t_bad_hdr();
    clear_model();
    hdr_lo_rsp = 32'h000B_8087;
    launch(16);
    wait_done();
    chk("R9 code", {29'b0, err_code}, 32'd4);
    chk("R8 acks", 32'(acks), 32'd4);
  endtask

  task automatic t_bad_off();
    clear_model();
    off_script[0] = 32'd20;
    launch(16);
    wait_done();
    chk("R10 code", {29'b0, err_code}, 32'd5);
  endtask

  task automatic t_proto();
    clear_model();
    rsp_stat = 32'h4;
    launch(16);
    wait_done();
    chk("R11 code", {29'b0, err_code}, 32'd6);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0; cyc = 0;
    start = 1'b0; img_len = '0; src_data = '0; mb_rdata = '0;
    clear_model();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_misaligned();
    t_normal();
    t_repeat();
    t_budget();
    t_status_err();
    t_timeout();
    t_bad_hdr();
    t_bad_off();
    t_proto();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule